// File: doc/BRIEF.md
# Dual-Mode Display Pixel FIFO

This block buffers 32-bit words between the DMA engine that fetches frame memory and the pixel datapath of a display controller. One storage array serves two layouts. With `dual_scan` low, the array acts as a single 512-word FIFO. With `dual_scan` high, it splits into two independent 256-word FIFOs: an upper-half FIFO and a lower-half FIFO. These feed the two halves of a dual-scan panel.

Each FIFO compares its own fill level against a programmable threshold on every cycle. It holds a level-type DMA request high while the level is below that threshold. Software normally programs the threshold as the effective FIFO depth minus twice the DMA burst length minus three. With that setting, a burst granted late still fits, and the FIFO stays close to full.

On the read side, the timing generator pulses `data_req` to pull one word. The word comes out one cycle later. In dual-scan mode, successive requests are served alternately from the upper FIFO and then the lower FIFO. A write to a full FIFO is lost, and a request to an empty FIFO returns nothing. Each of these two errors sets its own sticky flag.

Top module: `scan_pixel_fifo`

## Requirements
- R1: With `dual_scan`=0, every write goes to one FIFO of 512 words in first-in first-out order, whatever the value of `wr_half`. All 512 words are accepted before any write is refused.
- R2: With `dual_scan`=1, `wr_half`=0 writes the upper FIFO and `wr_half`=1 writes the lower FIFO. Each FIFO holds 256 words independently of the other.
- R3: In dual-scan mode, `data_req` pulses are served alternately from the upper FIFO, then the lower FIFO, then the upper FIFO again, and so on. The first pulse after a reset or a mode change goes to the upper FIFO. `rd_half` tells which FIFO supplied the word (0 upper, 1 lower).
- R4: A `data_req` to a non-empty FIFO produces `rd_valid`=1 with that word on `rd_data` in the following cycle. `rd_valid` is never high without a request one cycle earlier.
- R5: `dma_req[0]` is high exactly while the first FIFO (the single FIFO, or the upper FIFO in dual-scan mode) holds fewer words than `threshold`. It follows both the live occupancy and the live threshold as a level.
- R6: In dual-scan mode, `dma_req[1]` is high exactly while the lower FIFO holds fewer words than `threshold`. In single-scan mode, `dma_req[1]` stays 0.
- R7: A write to a full FIFO is dropped and sets `overflow`. `overflow` stays set until reset or a mode change.
- R8: A `data_req` to an empty FIFO gives `rd_valid`=0 and sets `underflow`. `underflow` stays set until reset or a mode change. In dual-scan mode, such a request still advances the alternation.
- R9: A change of `dual_scan` empties both FIFOs, clears both flags, and restarts the alternation at the upper FIFO. Any write or request in the cycle of the change is dropped.
- R10: While `rst` is high at a clock edge, all contents, flags and the alternation are cleared. After that edge, `rd_valid`, `overflow` and `underflow` are 0, and `dma_req[0]` is high whenever `threshold` is above 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_scan | input | 1 | 0 selects one deep FIFO, 1 selects two half FIFOs |
| threshold | input | 10 | Refill level; a request is raised below it |
| wr_en | input | 1 | Write strobe from the DMA side |
| wr_half | input | 1 | Target FIFO in dual-scan mode (0 upper, 1 lower) |
| wr_data | input | 32 | Word written |
| data_req | input | 1 | Read request from the timing generator |
| rd_valid | output | 1 | `rd_data` carries a word this cycle |
| rd_half | output | 1 | FIFO that supplied the current word |
| rd_data | output | 32 | Word read |
| dma_req | output | 2 | Refill request per FIFO, level |
| overflow | output | 1 | Sticky: a write to a full FIFO was dropped |
| underflow | output | 1 | Sticky: a request found its FIFO empty |

## Verification
Suppose a pointer or count goes wrong inside a FIFO. The fault shows at the ports within one cycle in one of three ways: `dma_req` flips at the wrong fill level, a wrong word or a wrong `rd_half` appears on the next read, or a flag sets too early or too late. The bench keeps its own queue model of both FIFOs and checks every output on every cycle, so such a fault is caught in the cycle it first becomes visible. A mistake in the alternation or in the write routing is seen as a swapped `rd_half` or a word from the wrong stream on the next read. A missed clear on a mode change shows as stale words or stale flags right after the switch.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned TOTAL_WORDS = 512;
    localparam int unsigned LANES       = 2;

    typedef enum logic {
        SCAN_SINGLE = 1'b0,
        SCAN_DUAL   = 1'b1
    } scan_mode_e;

    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } panel_half_e;

    // Tag that travels with a read through the output register
    typedef struct packed {
        logic        valid;
        panel_half_e half;
    } rd_tag_t;

    function automatic int unsigned ptr_bits(int unsigned words);
        return $clog2(words);
    endfunction

endpackage

// File: rtl/pfifo_lane.sv
// Pointer and occupancy unit for one logical FIFO inside the shared array.
module pfifo_lane #(
    parameter int unsigned AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [AW:0]   cap,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [AW:0]   count,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          push_drop,
    output logic          pop_miss
);

    localparam int unsigned CW = AW + 1;

    logic full, empty;
    logic [AW:0] cap_last;

    assign full      = (count >= cap);
    assign empty     = (count == '0);
    assign push_ok   = push & ~full;
    assign pop_ok    = pop & ~empty;
    assign push_drop = push & full;
    assign pop_miss  = pop & empty;
    assign cap_last  = cap - CW'(1);

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p, input logic [AW:0] last);
        return ({1'b0, p} == last) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= advance(wptr, cap_last);
            if (pop_ok)  rptr <= advance(rptr, cap_last);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assert_count_cap_R1: assert property (@(posedge clk) disable iff (rst)
        count <= cap);

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !clr) |=> (count == $past(count)));

    assert_empty_miss_R8: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !clr) |=> (count == '0));

endmodule

// File: rtl/pfifo_store.sv
// Shared word array with one write and one registered read per cycle.
module pfifo_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 512
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/scan_pixel_fifo.sv
module scan_pixel_fifo
    import pfifo_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned DEPTH  = TOTAL_WORDS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       dual_scan,
    input  logic [$clog2(DEPTH):0]     threshold,
    input  logic                       wr_en,
    input  logic                       wr_half,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       data_req,
    output logic                       rd_valid,
    output logic                       rd_half,
    output logic [DATA_W-1:0]          rd_data,
    output logic [1:0]                 dma_req,
    output logic                       overflow,
    output logic                       underflow
);

    localparam int unsigned AW   = ptr_bits(DEPTH);
    localparam int unsigned CW   = AW + 1;
    localparam int unsigned HALF = DEPTH / 2;
    localparam logic [AW:0]   CAP_FULL  = CW'(DEPTH);
    localparam logic [AW:0]   CAP_HALF  = CW'(HALF);
    localparam logic [AW-1:0] BASE_LOW  = AW'(HALF);

    scan_mode_e mode_q;
    scan_mode_e mode_in;
    logic       clr;
    logic       dual;
    logic       rd_sel_q;
    logic       wr_tgt;
    logic       rd_src;
    rd_tag_t    tag_q;
    logic       ovf_q, udf_q;

    logic [LANES-1:0]         push, pop, push_ok, pop_ok, push_drop, pop_miss;
    logic [LANES-1:0][AW-1:0] wptr, rptr;
    logic [LANES-1:0][AW:0]   count;
    logic [LANES-1:0][AW:0]   lane_cap;

    logic [AW-1:0] waddr, raddr;

    assign mode_in = scan_mode_e'(dual_scan);
    assign clr     = (mode_in != mode_q);
    assign dual    = (mode_q == SCAN_DUAL);
    assign wr_tgt  = dual & wr_half;
    assign rd_src  = dual & rd_sel_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_cap[g] = (g == 0 && !dual) ? CAP_FULL : CAP_HALF;
        assign push[g]     = wr_en    & ~clr & (wr_tgt == 1'(g));
        assign pop[g]      = data_req & ~clr & (rd_src == 1'(g));

        pfifo_lane #(.AW(AW)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .clr       (clr),
            .cap       (lane_cap[g]),
            .push      (push[g]),
            .pop       (pop[g]),
            .wptr      (wptr[g]),
            .rptr      (rptr[g]),
            .count     (count[g]),
            .push_ok   (push_ok[g]),
            .pop_ok    (pop_ok[g]),
            .push_drop (push_drop[g]),
            .pop_miss  (pop_miss[g])
        );
    end

    assign waddr = wr_tgt ? (BASE_LOW + wptr[1]) : wptr[0];
    assign raddr = rd_src ? (BASE_LOW + rptr[1]) : rptr[0];

    pfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (|push_ok),
        .waddr (waddr),
        .wdata (wr_data),
        .re    (|pop_ok),
        .raddr (raddr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mode_q   <= mode_in;
            rd_sel_q <= 1'b0;
            tag_q    <= '0;
            ovf_q    <= 1'b0;
            udf_q    <= 1'b0;
        end else begin
            tag_q.valid <= |pop_ok;
            tag_q.half  <= panel_half_e'(rd_src);
            if (|push_drop)          ovf_q    <= 1'b1;
            if (|pop_miss)           udf_q    <= 1'b1;
            if (data_req && dual)    rd_sel_q <= ~rd_sel_q;
        end
    end

    assign rd_valid   = tag_q.valid;
    assign rd_half    = tag_q.half;
    assign overflow   = ovf_q;
    assign underflow  = udf_q;
    assign dma_req[0] = (count[0] < threshold);
    assign dma_req[1] = dual & (count[1] < threshold);

    assert_valid_after_req_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(data_req));

    assert_lower_idle_single_R6: assert property (@(posedge clk) disable iff (rst)
        (!dual_scan && $past(!dual_scan)) |-> !dma_req[1]);

    assert_overflow_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (overflow && mode_in == mode_q) |=> overflow);

    assert_underflow_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (underflow && mode_in == mode_q) |=> underflow);

    assert_sel_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        (dual && !clr && data_req) |=> (rd_sel_q != $past(rd_sel_q)));

endmodule

// File: tb/sim_scan_pixel_fifo.sv
module sim_scan_pixel_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam int HALF       = DEPTH / 2;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        dual_scan;
    logic [9:0]  thr;
    logic        wr_en, wr_half, data_req;
    logic [31:0] wr_data;
    logic        rd_valid, rd_half, overflow, underflow;
    logic [31:0] rd_data;
    logic [1:0]  dma_req;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scan_pixel_fifo u0 (
        .clk (clk), .rst (rst), .dual_scan (dual_scan), .threshold (thr),
        .wr_en (wr_en), .wr_half (wr_half), .wr_data (wr_data),
        .data_req (data_req), .rd_valid (rd_valid), .rd_half (rd_half),
        .rd_data (rd_data), .dma_req (dma_req),
        .overflow (overflow), .underflow (underflow)
    );

    // Behavioural reference: two queues and a few flags
    logic [31:0] q0 [$];
    logic [31:0] q1 [$];
    logic        m_dual = 1'b0, m_sel = 1'b0, m_ovf = 1'b0, m_udf = 1'b0;
    logic        e_valid = 1'b0, e_half = 1'b0;
    logic [31:0] e_data = '0;
    int          checks = 0, fails = 0, wd = 0;
    bit          done = 0;

    always @(posedge clk) begin : model
        int s0, s1, cap0;
        logic src, tgt;
        if (rst || dual_scan != m_dual) begin
            q0.delete(); q1.delete();
            m_dual = dual_scan; m_sel = 1'b0; m_ovf = 1'b0; m_udf = 1'b0; e_valid = 1'b0;
        end else begin
            s0 = q0.size(); s1 = q1.size();
            cap0 = m_dual ? HALF : DEPTH;
            src = m_dual & m_sel;
            tgt = m_dual & wr_half;
            e_valid = 1'b0;
            if (data_req) begin
                if (!src) begin
                    if (s0 > 0) begin e_data = q0.pop_front(); e_valid = 1'b1; e_half = 1'b0; end
                    else m_udf = 1'b1;
                end else begin
                    if (s1 > 0) begin e_data = q1.pop_front(); e_valid = 1'b1; e_half = 1'b1; end
                    else m_udf = 1'b1;
                end
                if (m_dual) m_sel = ~m_sel;
            end
            if (wr_en) begin
                if (!tgt) begin
                    if (s0 < cap0) q0.push_back(wr_data); else m_ovf = 1'b1;
                end else begin
                    if (s1 < HALF) q1.push_back(wr_data); else m_ovf = 1'b1;
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp();
        chk("R4 rd_valid", 32'(rd_valid), 32'(e_valid));
        if (e_valid) begin
            chk("R4 rd_data", rd_data, e_data);
            chk("R3 rd_half", 32'(rd_half), 32'(e_half));
        end
        chk("R5 dma_req[0]", 32'(dma_req[0]), 32'(q0.size() < int'(thr)));
        chk("R6 dma_req[1]", 32'(dma_req[1]), 32'(m_dual && (q1.size() < int'(thr))));
        chk("R7 overflow", 32'(overflow), 32'(m_ovf));
        chk("R8 underflow", 32'(underflow), 32'(m_udf));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp();
    endtask

    task automatic idle();
        wr_en = 1'b0; data_req = 1'b0;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > WATCHDOG && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", wd, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; dual_scan = 1'b0; thr = 10'd100;
        wr_en = 1'b0; wr_half = 1'b0; wr_data = '0; data_req = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        chk("R10 rd_valid after reset", 32'(rd_valid), 32'd0);
        chk("R10 overflow after reset", 32'(overflow), 32'd0);
        chk("R10 underflow after reset", 32'(underflow), 32'd0);
        chk("R10 dma_req after reset", 32'(dma_req), 32'd1);

        // Single scan: fill all 512 words, wr_half toggling and ignored
        for (int i = 0; i < DEPTH; i++) begin
            wr_en = 1'b1; wr_half = i[0]; wr_data = 32'hA000_0000 + i;
            step();
        end
        chk("R1 512 words accepted", 32'(overflow), 32'd0);
        chk("R5 full single fifo drops request", 32'(dma_req[0]), 32'd0);
        wr_data = 32'hDEAD_0001;
        step();
        chk("R7 write to full sets overflow", 32'(overflow), 32'd1);
        idle();
        for (int i = 0; i < DEPTH; i++) begin
            data_req = 1'b1;
            step();
            if (i == 0) chk("R1 first word out", rd_data, 32'hA000_0000);
            if (i == DEPTH - 1) chk("R1 last word out", rd_data, 32'hA000_01FF);
        end
        step();
        chk("R8 empty request sets underflow", 32'(underflow), 32'd1);
        chk("R8 empty request gives no data", 32'(rd_valid), 32'd0);
        idle();
        step();

        // Threshold as a live level
        rst = 1'b1; step(); rst = 1'b0;
        chk("R10 flags cleared by reset", 32'({overflow, underflow}), 32'd0);
        thr = 10'd4;
        for (int i = 0; i < 3; i++) begin wr_en = 1'b1; wr_data = 32'h5100 + i; step(); end
        chk("R5 three words below four", 32'(dma_req[0]), 32'd1);
        wr_data = 32'h5103; step();
        idle();
        chk("R5 four words reach threshold", 32'(dma_req[0]), 32'd0);
        thr = 10'd5;
        #1;
        chk("R5 threshold raised live", 32'(dma_req[0]), 32'd1);
        @(negedge clk);
        cmp();

        // Mode change with a write in the same cycle
        dual_scan = 1'b1; wr_en = 1'b1; wr_half = 1'b0; wr_data = 32'hBAD0_0000;
        step();
        idle();
        chk("R9 both fifos empty after switch", 32'(dma_req), 32'd3);
        data_req = 1'b1; step(); idle();
        chk("R9 change-cycle write dropped", 32'(rd_valid), 32'd0);
        step();

        // Dual scan: upper filled to 256, lower gets 10
        rst = 1'b1; step(); rst = 1'b0;
        thr = 10'd250;
        for (int i = 0; i < HALF; i++) begin
            wr_en = 1'b1; wr_half = 1'b0; wr_data = 32'hB000_0000 + i; step();
        end
        for (int i = 0; i < 10; i++) begin
            wr_en = 1'b1; wr_half = 1'b1; wr_data = 32'hC000_0000 + i; step();
        end
        chk("R2 upper holds 256 words", 32'(overflow), 32'd0);
        chk("R2 per-fifo requests", 32'(dma_req), 32'd2);
        wr_half = 1'b0; wr_data = 32'hDEAD_0002; step();
        chk("R7 upper full sets overflow", 32'(overflow), 32'd1);
        idle();
        for (int i = 0; i < 22; i++) begin
            data_req = 1'b1; step();
            if (i == 0) chk("R3 first read from upper", {31'd0, rd_half}, 32'd0);
            if (i == 1) chk("R3 second read from lower", rd_data, 32'hC000_0000);
        end
        idle();
        chk("R8 lower empty sets underflow", 32'(underflow), 32'd1);
        step();

        // Back to single: lower request idle, wr_half ignored
        dual_scan = 1'b0; step();
        thr = 10'd512;
        wr_en = 1'b1; wr_half = 1'b1; wr_data = 32'h7777_0001; step();
        idle();
        chk("R6 lower request low in single", 32'(dma_req), 32'd1);
        data_req = 1'b1; step(); idle();
        chk("R1 wr_half ignored in single", rd_data, 32'h7777_0001);
        step();

        // Mixed traffic with mode flips and resets
        for (int i = 0; i < 6000; i++) begin
            if (i % 250 == 0) thr = 10'($urandom % 520);
            if (i % 1500 == 700) dual_scan = ~dual_scan;
            rst      = (i % 2000 == 1999);
            wr_en    = (($urandom % 4) != 0);
            wr_half  = 1'($urandom);
            wr_data  = $urandom;
            data_req = ((i / 400) % 2 == 0) ? (($urandom % 3) == 0) : (($urandom % 4) != 0);
            step();
        end
        rst = 1'b0; idle(); step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule